// File: doc/BRIEF.md
# Serial Clock Divider with Sample Timing

This block produces the serial clock for a SPI master from the bus clock. Two ways of dividing are available: a linear scheme, where an 8-bit value `n` gives a ratio of 2*(n+1), and a power-of-two scheme, where a 4-bit exponent `n` gives a ratio of 2^n. One select bit picks the scheme. A select value of 0, the power-of-two scheme, is the default. After reset the held configuration is linear field 2, exponent 0 and power-of-two scheme.

The block has no external clock output of its own. It drives a registered serial clock level, which is low when idle. It also gives single-cycle strobes in the bus clock domain. A leading strobe marks the cycle just before the serial clock rises, and a trailing strobe marks the cycle just before it falls. A sample strobe tells the shift logic when to capture the incoming data bit. Normally the sample strobe coincides with the leading strobe. When delayed capture is requested and the normal-sample bit is clear, the sample strobe fires one bus cycle later, which gives high-speed links more input timing margin.

The shift logic raises `run_i` to start a transfer. All configuration inputs are captured at that moment and held until the transfer ends. The serial clock runs while `run_i` stays high. Once `run_i` is low, the clock stops at the next trailing edge, so a cycle is never cut short.

Top module: `spi_sclk_divgen`

## Requirements
- R1: After reset, and while no transfer is running, `sclk_o`, `lead_o`, `trail_o` and `smp_o` are all 0.
- R2: With `div_sel_i`=1 (linear scheme), each half period of the serial clock lasts `div_lin_i`+1 bus cycles, giving a full period of 2*(`div_lin_i`+1).
- R3: With `div_sel_i`=0 (power-of-two scheme) and `div_exp_i`=e with e>=1, each half period lasts 2^(e-1) bus cycles, giving a full period of 2^e.
- R4: With `div_sel_i`=0 and `div_exp_i`=0, the half period is clamped to one bus cycle, so the leading and trailing strobes alternate on consecutive cycles.
- R5: The value of `div_sel_i` picks the scheme: 1 selects linear and 0 selects power-of-two. Only the field of the selected scheme has any effect.
- R6: Let cycle 0 be the first cycle after the clock edge that samples `run_i` high from idle, and let H be the half period. The leading strobe then occurs at cycles H-1+2Hm and the trailing strobe at 2H-1+2Hm. `sclk_o` is 1 exactly in the cycles after a leading strobe, up to and including the next trailing strobe.
- R7: Changes to `div_sel_i`, `div_lin_i`, `div_exp_i`, `smp_dly_i` and `smp_norm_i` while a transfer is running do not affect that transfer.
- R8: If `run_i` is low at the clock edge that ends a trailing-strobe cycle, the transfer stops. From the next cycle on, `sclk_o` is 0 and no strobes fire.
- R9: When the captured `smp_norm_i`=1 or the captured `smp_dly_i`=0, `smp_o` equals `lead_o` in every cycle.
- R10: When the captured `smp_dly_i`=1 and the captured `smp_norm_i`=0, `smp_o` fires exactly one bus cycle after each leading strobe.
- R11: `lead_o` and `trail_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Transfer request level; a rise while idle starts the clock |
| div_sel_i | input | 1 | Scheme select: 1 linear, 0 power-of-two |
| div_lin_i | input | 8 | Linear divider field n, ratio 2*(n+1) |
| div_exp_i | input | 4 | Power-of-two exponent n, ratio 2^n |
| smp_dly_i | input | 1 | Request delayed data capture |
| smp_norm_i | input | 1 | Force normal capture timing when 1 |
| sclk_o | output | 1 | Serial clock level, idle low |
| lead_o | output | 1 | Strobe in the cycle before the serial clock rises |
| trail_o | output | 1 | Strobe in the cycle before the serial clock falls |
| smp_o | output | 1 | Data capture strobe |

## Verification
The hardest case to reach from the ports is a configuration change that lands inside a running transfer. A glitch there shows up only as a half period that is too long or too short, somewhere in the middle of the transfer. To reach it, every case in the sweep inverts all the configuration inputs one cycle after the start. The bench then checks each later cycle against the timing of the original settings. The stop condition is reached in the same way: `run_i` is dropped during the final period, before its trailing edge, so the clock must finish that period and then fall silent. The sweep covers every exponent, a range of linear values including the largest, and all four sample-mode combinations.

// File: rtl/spi_div_pkg.sv
// Shared sizing for the serial clock divider.
// Assumes the exponent field stays small enough that 2^(2^EXP_W-2) fits in a counter.
package spi_div_pkg;
    localparam int unsigned DEF_LIN_W = 8;
    localparam int unsigned DEF_EXP_W = 4;
    localparam logic [7:0]  RST_LIN   = 8'd2;

    // Counter width that holds the largest half period of either scheme.
    function automatic int unsigned half_width(input int unsigned lin_w, input int unsigned exp_w);
        int unsigned pw;
        pw = (1 << exp_w) - 1;
        return ((lin_w + 1) > pw) ? (lin_w + 1) : pw;
    endfunction
endpackage

// File: rtl/spi_half_calc.sv
// Half-period calculator: turns the divider fields into a half period in bus cycles.
// Assumes expo is never large enough to shift past CNT_W-1.
module spi_half_calc #(
    parameter int unsigned LIN_W = 8,
    parameter int unsigned EXP_W = 4,
    parameter int unsigned CNT_W = 15
) (
    input  logic             sel,
    input  logic [LIN_W-1:0] lin,
    input  logic [EXP_W-1:0] expo,
    output logic [CNT_W-1:0] half
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Pick linear (n+1) or power-of-two (2^(n-1), clamped at 1).
    always_comb begin
        if (sel) begin
            half = CNT_W'(lin) + ONE;
        end else if (expo == '0) begin
            half = ONE;
        end else begin
            half = ONE << (expo - EXP_W'(1));
        end
    end
endmodule

// File: rtl/spi_edge_timer.sv
// Edge timer: counts half periods and issues leading/trailing strobes.
// Assumes half >= 1 and stays stable while active is high.
module spi_edge_timer #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             active,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic             edge_now;

    assign edge_now  = active && (cnt_q == '0);
    assign lead_stb  = edge_now && !phase_q;
    assign trail_stb = edge_now && phase_q;
    assign sclk      = phase_q;

    // Start on run, reload each half period, stop after a trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!active) begin
            phase_q <= 1'b0;
            if (run) begin
                active <= 1'b1;
                cnt_q  <= half - CNT_W'(1);
            end
        end else if (edge_now) begin
            cnt_q <= half - CNT_W'(1);
            if (!phase_q) begin
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                if (!run) begin
                    active <= 1'b0;
                end
            end
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    p_lead_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |=> sclk);
    p_trail_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |=> !sclk);
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_stb && !run) |=> (!lead_stb && !trail_stb && !sclk));
    p_half_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(half));
    p_edges_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |=> !lead_stb);
endmodule

// File: rtl/spi_sample_gen.sv
// Sample strobe generator: passes the leading strobe or a one-cycle-late copy.
// Assumes late is held constant for the whole transfer.
module spi_sample_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic late,
    input  logic lead_stb,
    output logic smp_stb
);
    logic lead_q;

    // Remember last cycle's leading strobe for the delayed capture point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= 1'b0;
        end else begin
            lead_q <= lead_stb;
        end
    end

    assign smp_stb = late ? lead_q : lead_stb;

    p_late_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (late && lead_stb) |=> smp_stb);
    p_smp_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> (lead_stb || $past(lead_stb)));
endmodule

// File: rtl/spi_sclk_divgen.sv
// Serial clock divider top: captures configuration at transfer start and
// drives the edge timer and the sample strobe generator.
// Assumes master operation; polarity and phase mapping happen downstream.
module spi_sclk_divgen #(
    parameter int unsigned LIN_W = spi_div_pkg::DEF_LIN_W,
    parameter int unsigned EXP_W = spi_div_pkg::DEF_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             div_sel_i,
    input  logic [LIN_W-1:0] div_lin_i,
    input  logic [EXP_W-1:0] div_exp_i,
    input  logic             smp_dly_i,
    input  logic             smp_norm_i,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o,
    output logic             smp_o
);
    localparam int unsigned CNT_W = spi_div_pkg::half_width(LIN_W, EXP_W);

    logic             active;
    logic             sel_q, late_q;
    logic [LIN_W-1:0] lin_q;
    logic [EXP_W-1:0] exp_q;
    logic             sel_use;
    logic [LIN_W-1:0] lin_use;
    logic [EXP_W-1:0] exp_use;
    logic [CNT_W-1:0] half;
    logic             starting;

    assign starting = !active && run_i;

    // Capture the configuration when a transfer begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            lin_q  <= LIN_W'(spi_div_pkg::RST_LIN);
            exp_q  <= '0;
            late_q <= 1'b0;
        end else if (starting) begin
            sel_q  <= div_sel_i;
            lin_q  <= div_lin_i;
            exp_q  <= div_exp_i;
            late_q <= smp_dly_i && !smp_norm_i;
        end
    end

    // Use the live fields for the first load, the held ones while running.
    always_comb begin
        sel_use = active ? sel_q : div_sel_i;
        lin_use = active ? lin_q : div_lin_i;
        exp_use = active ? exp_q : div_exp_i;
    end

    spi_half_calc #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) half_i (
        .sel  (sel_use),
        .lin  (lin_use),
        .expo (exp_use),
        .half (half)
    );

    spi_edge_timer #(.CNT_W(CNT_W)) edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_i),
        .half      (half),
        .active    (active),
        .sclk      (sclk_o),
        .lead_stb  (lead_o),
        .trail_stb (trail_o)
    );

    spi_sample_gen smp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .late     (late_q),
        .lead_stb (lead_o),
        .smp_stb  (smp_o)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (!sclk_o && !lead_o && !trail_o && !smp_o));
    p_late_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> ($stable(late_q) && $stable(sel_q)));
endmodule

// File: tb/spi_sclk_divgen_tb.sv
// Sweep bench for the serial clock divider; expected timing computed arithmetically.
module spi_sclk_divgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       div_sel_i = 1'b0;
    logic [7:0] div_lin_i = 8'd0;
    logic [3:0] div_exp_i = 4'd0;
    logic       smp_dly_i = 1'b0;
    logic       smp_norm_i = 1'b0;
    logic       sclk_o, lead_o, trail_o, smp_o;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_sclk_divgen dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .div_sel_i(div_sel_i),
        .div_lin_i(div_lin_i), .div_exp_i(div_exp_i), .smp_dly_i(smp_dly_i),
        .smp_norm_i(smp_norm_i), .sclk_o(sclk_o), .lead_o(lead_o),
        .trail_o(trail_o), .smp_o(smp_o)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit act, input bit exp, input string tag, input int k);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, k, act, exp);
        end
    endtask

    task automatic run_case(input bit sel, input int lin, input int ex, input bit dly, input bit nrm);
        int h, p, total;
        bit late;
        string ctag;
        h = sel ? lin + 1 : ((ex == 0) ? 1 : (1 << (ex - 1)));
        p = (h <= 8) ? 3 : 1;
        total = p * 2 * h;
        late = dly && !nrm;
        ctag = sel ? "R2/R5/R7" : ((ex == 0) ? "R4/R5/R7" : "R3/R5/R7");
        @(negedge clk);
        div_sel_i = sel; div_lin_i = 8'(lin); div_exp_i = 4'(ex);
        smp_dly_i = dly; smp_norm_i = nrm; run_i = 1'b1;
        @(negedge clk);
        for (int k = 0; k < total + 4; k++) begin
            bit in_x, el, et, es, esc;
            int ph;
            if (k == 1) begin
                div_sel_i = ~sel; div_lin_i = ~8'(lin); div_exp_i = ~4'(ex);
                smp_dly_i = ~dly; smp_norm_i = ~nrm;
            end
            in_x = (k < total);
            ph = k % (2 * h);
            el = in_x && (ph == h - 1);
            et = in_x && (ph == 2 * h - 1);
            esc = in_x && (ph >= h);
            if (late) es = (k >= 1) && (k - 1 < total) && (((k - 1) % (2 * h)) == h - 1);
            else es = el;
            if (in_x) begin
                check(lead_o, el, {ctag, " lead"}, k);
                check(trail_o, et, {ctag, " trail"}, k);
                check(sclk_o, esc, "R6 sclk", k);
                check(smp_o, es, late ? "R10 sample" : "R9 sample", k);
            end else begin
                check(lead_o | trail_o | sclk_o, 1'b0, "R8 after stop", k);
                check(smp_o, es, late ? "R10 sample" : "R8 sample", k);
            end
            check(lead_o & trail_o, 1'b0, "R11 overlap", k);
            if (k == (p - 1) * 2 * h) run_i = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sclk_o | lead_o | trail_o | smp_o, 1'b0, "R1 in reset", 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(sclk_o | lead_o | trail_o | smp_o, 1'b0, "R1 idle", i);
        end
        for (int e = 0; e < 16; e++) begin
            run_case(1'b0, 200, e, e[0], e[1]);
        end
        for (int n = 0; n < 21; n++) begin
            run_case(1'b1, n, 9, n[0], n[1]);
        end
        run_case(1'b1, 63, 0, 1'b1, 1'b0);
        run_case(1'b1, 255, 0, 1'b0, 1'b0);
        run_case(1'b1, 255, 0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(sclk_o | lead_o | trail_o | smp_o, 1'b0, "R1 idle at end", i);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule